// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block produces the address-latch pulse and the active-low program-read strobe for a multiplexed external memory bus. The core it serves runs machine cycles of twelve oscillator clocks. The block counts the phases of each machine cycle and decodes them into strobes. At the boundary between machine cycles it samples four things for the cycle that follows:

- whether that cycle moves external data;
- whether it reads a code table;
- the latch-gating control bit;
- whether the fetch goes to internal or external program memory.

The internal/external choice comes from the external-access pin and the fetch address. With the pin low, every fetch goes external. With the pin high, only fetches above the top of the internal region go external.

In an ordinary cycle the latch pulse appears twice, at one sixth of the oscillator rate. An external-data cycle loses its second pulse. A code-table cycle keeps both pulses. Setting the gating bit removes the pulses from every cycle that does neither kind of access. The program-read strobe fires twice per external-fetch cycle, each time just after a latch pulse window. It stays quiet for internal fetches and for external-data cycles.

The block also qualifies the reset pin. Reset is held only after the pin has stayed high for two full machine cycles. While reset is held, both strobes stay idle. The first machine cycle starts on the clock where the held reset drops.

Top module: `xbus_strobe_seq`

## Requirements
- R1: A machine cycle is 12 clocks, numbered phase 0 to 11. In a cycle with the gating bit clear and no external-data access, `ale` is high in phases 0, 1, 6 and 7 and low in every other phase.
- R2: In an external-data cycle (`xdata_cyc`=1), `ale` is high in phases 0 and 1 only; the phase 6–7 pulse is omitted.
- R3: With `ale_gate`=1, `ale` stays low for the whole cycle unless the cycle is external-data or code-table. A code-table cycle gets both pulses; an external-data cycle gets only the phase 0–1 pulse.
- R4: In an external-fetch cycle that is not external-data, `psen_n` is low in phases 2–5 and 8–11 and high in the other phases. `ale` and a low `psen_n` never coincide.
- R5: In an external-data cycle, `psen_n` stays high for all 12 phases.
- R6: In an internal-fetch cycle, `psen_n` stays high for all 12 phases.
- R7: With `ea_pin`=0, the fetch is external for every address, 0000h and FFFFh included; `ext_fetch` is 1 for that cycle.
- R8: With `ea_pin`=1, the fetch is external only when `fetch_addr` > 0FFFh. Address 0FFFh gives `ext_fetch`=0; address 1000h gives `ext_fetch`=1.
- R9: The per-cycle inputs are sampled at the clock edge that ends phase 11 and govern the whole following cycle. Changes to them during phases 0–10 have no effect on that cycle.
- R10: `rst_held` rises at the 24th consecutive clock edge that samples `rst_pin` high. 23 such edges leave it low. It falls at the first edge that samples `rst_pin` low.
- R11: While `rst_held` is 1, `ale`=0 and `psen_n`=1. Phase 0 of a new machine cycle begins at the edge where `rst_held` falls.
- R12: While `rst_n`=0, `ale`=0, `psen_n`=1, `rst_held`=0 and `ext_fetch`=0. The first edge after `rst_n` is released starts phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low initialisation of the block's flops |
| rst_pin | input | 1 | Raw reset pin, qualified over two machine cycles |
| ea_pin | input | 1 | External-access pin level |
| fetch_addr | input | 16 | Program fetch address for the next cycle |
| xdata_cyc | input | 1 | Next cycle accesses external data memory |
| code_tbl_cyc | input | 1 | Next cycle reads a code table |
| ale_gate | input | 1 | Restrict latch pulses to data/table cycles |
| ale | output | 1 | Address latch enable strobe |
| psen_n | output | 1 | Active-low program store read strobe |
| ext_fetch | output | 1 | Current cycle fetches from external program memory |
| rst_held | output | 1 | Qualified reset level |

## Verification
Latch gating and external-data pulse suppression can apply in the same machine cycle, and so can the internal/external fetch choice. Together these decide both strobes of that cycle. The bench sweeps every combination of the data, table and gating flags against both pin levels and the four boundary addresses 0000h, 0FFFh, 1000h and FFFFh. For each cycle it compares the observed 12-phase `ale` and `psen_n` patterns with patterns computed arithmetically from the flags. The qualified reset can also start or end on any phase of a running cycle. The bench holds the pin for 23 and for 30 edges, then judges the rise edge, the idle strobes and the restart at phase 0.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    // Per-machine-cycle context captured at the cycle boundary
    typedef struct packed {
        logic xdata;     // external data access this cycle
        logic code_tbl;  // code table read this cycle
        logic ale_gate;  // latch pulses restricted to data/table cycles
        logic ext;       // program fetch goes to external memory
    } cyc_ctx_t;

endpackage

// File: rtl/xbus_rst_hold.sv
module xbus_rst_hold #(
    parameter int HOLD_CLKS = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic held_d,
    output logic held_q
);

    localparam int CW = (HOLD_CLKS > 1) ? $clog2(HOLD_CLKS) : 1;
    localparam logic [CW-1:0] SAT = CW'(HOLD_CLKS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          held;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!pin) begin
            st_d.cnt  = '0;
            st_d.held = 1'b0;
        end else begin
            st_d.held = (st_q.cnt == SAT);
            if (st_q.cnt != SAT) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign held_d = st_d.held;
    assign held_q = st_q.held;

    // R10
    held_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.held |-> (st_q.cnt == SAT));

    // R10
    held_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pin |=> !st_q.held);

endmodule

// File: rtl/xbus_cycle_track.sv
module xbus_cycle_track
    import xbus_pkg::*;
#(
    parameter int          MC_LEN  = 12,
    parameter int          ADDR_W  = 16,
    parameter int unsigned INT_TOP = 32'h0FFF,
    localparam int         PW      = $clog2(MC_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              held_d,
    input  logic              ea_pin,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              xdata_cyc,
    input  logic              code_tbl_cyc,
    input  logic              ale_gate,
    output logic [PW-1:0]     phase_d,
    output cyc_ctx_t          ctx_d,
    output logic              ext_q,
    output logic              xdata_q
);

    localparam logic [PW-1:0]     LAST = PW'(MC_LEN - 1);
    localparam logic [ADDR_W-1:0] TOP  = ADDR_W'(INT_TOP);

    typedef struct packed {
        logic [PW-1:0] phase;
        cyc_ctx_t      ctx;
    } st_t;

    st_t  st_d, st_q;
    logic at_last;
    logic ext_now;

    always_comb begin
        at_last = (st_q.phase == LAST);
        ext_now = !ea_pin || (fetch_addr > TOP);
        st_d    = st_q;
        if (held_d) begin
            st_d.phase = LAST;
        end else if (at_last) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + 1'b1;
        end
        if (at_last) begin
            st_d.ctx.xdata    = xdata_cyc;
            st_d.ctx.code_tbl = code_tbl_cyc;
            st_d.ctx.ale_gate = ale_gate;
            st_d.ctx.ext      = ext_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= LAST;
            st_q.ctx   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_d = st_d.phase;
    assign ctx_d   = st_d.ctx;
    assign ext_q   = st_q.ctx.ext;
    assign xdata_q = st_q.ctx.xdata;

    // R9
    ctx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase != LAST) |=> $stable(st_q.ctx));

    // R1
    phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == LAST) |=> (st_q.phase == '0 || st_q.phase == LAST));

    // R1
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.phase <= LAST);

endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
    import xbus_pkg::*;
#(
    parameter int  MC_LEN = 12,
    parameter int  ALE_W  = 2,
    localparam int PW     = $clog2(MC_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          held_d,
    input  logic [PW-1:0] phase_d,
    input  cyc_ctx_t      ctx_d,
    output logic          ale,
    output logic          psen_n
);

    localparam logic [PW-1:0] HALF    = PW'(MC_LEN / 2);
    localparam logic [PW-1:0] W_A_END = PW'(ALE_W);
    localparam logic [PW-1:0] W_B_END = PW'(MC_LEN / 2 + ALE_W);

    if (ALE_W < 1 || ALE_W >= MC_LEN / 2) begin : g_bad_width
        initial $error("latch pulse width must lie inside a half cycle");
    end

    typedef struct packed {
        logic ale;
        logic psen_n;
    } st_t;

    st_t  st_d, st_q;
    logic win_a, win_b, win_rd, ale_en, rd_en;

    always_comb begin
        win_a  = (phase_d < W_A_END);
        win_b  = (phase_d >= HALF) && (phase_d < W_B_END);
        win_rd = !win_a && !win_b;
        ale_en = !ctx_d.ale_gate || ctx_d.xdata || ctx_d.code_tbl;
        rd_en  = ctx_d.ext && !ctx_d.xdata;
        st_d.ale    = !held_d && ale_en && (win_a || (win_b && !ctx_d.xdata));
        st_d.psen_n = !(!held_d && rd_en && win_rd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ale    <= 1'b0;
            st_q.psen_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ale    = st_q.ale;
    assign psen_n = st_q.psen_n;

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.ale && !st_q.psen_n));

    // R1
    ale_min_chk: assert property (@(posedge clk) disable iff (!rst_n || held_d)
        $rose(st_q.ale) |=> st_q.ale);

    // R1
    ale_width_chk: assert property (@(posedge clk) disable iff (!rst_n || held_d)
        $fell(st_q.ale) |-> $past(st_q.ale, 2));

endmodule

// File: rtl/xbus_strobe_seq.sv
module xbus_strobe_seq
    import xbus_pkg::*;
#(
    parameter int          MC_LEN   = 12,
    parameter int          ALE_W    = 2,
    parameter int          RST_MCS  = 2,
    parameter int          ADDR_W   = 16,
    parameter int unsigned INT_TOP  = 32'h0FFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_pin,
    input  logic              ea_pin,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              xdata_cyc,
    input  logic              code_tbl_cyc,
    input  logic              ale_gate,
    output logic              ale,
    output logic              psen_n,
    output logic              ext_fetch,
    output logic              rst_held
);

    localparam int PW        = $clog2(MC_LEN);
    localparam int HOLD_CLKS = RST_MCS * MC_LEN;

    logic          held_d;
    logic          held_q;
    logic [PW-1:0] phase_d;
    cyc_ctx_t      ctx_d;
    logic          ext_q;
    logic          xdata_q;

    xbus_rst_hold #(
        .HOLD_CLKS (HOLD_CLKS)
    ) u_rst_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin    (rst_pin),
        .held_d (held_d),
        .held_q (held_q)
    );

    xbus_cycle_track #(
        .MC_LEN  (MC_LEN),
        .ADDR_W  (ADDR_W),
        .INT_TOP (INT_TOP)
    ) u_cycle_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .held_d       (held_d),
        .ea_pin       (ea_pin),
        .fetch_addr   (fetch_addr),
        .xdata_cyc    (xdata_cyc),
        .code_tbl_cyc (code_tbl_cyc),
        .ale_gate     (ale_gate),
        .phase_d      (phase_d),
        .ctx_d        (ctx_d),
        .ext_q        (ext_q),
        .xdata_q      (xdata_q)
    );

    xbus_strobe_gen #(
        .MC_LEN (MC_LEN),
        .ALE_W  (ALE_W)
    ) u_strobe_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .held_d  (held_d),
        .phase_d (phase_d),
        .ctx_d   (ctx_d),
        .ale     (ale),
        .psen_n  (psen_n)
    );

    assign ext_fetch = ext_q;
    assign rst_held  = held_q;

    // R11
    held_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_held |-> (!ale && psen_n));

    // R5
    xdata_psen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xdata_q |-> psen_n);

    // R6
    int_psen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_q |-> psen_n);

endmodule

// File: tb/xbus_strobe_seq_tb.sv
module xbus_strobe_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n, rst_pin, ea_pin;
    logic [15:0] fetch_addr;
    logic        xdata_cyc, code_tbl_cyc, ale_gate;
    logic        ale, psen_n, ext_fetch, rst_held;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    xbus_strobe_seq u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .rst_pin      (rst_pin),
        .ea_pin       (ea_pin),
        .fetch_addr   (fetch_addr),
        .xdata_cyc    (xdata_cyc),
        .code_tbl_cyc (code_tbl_cyc),
        .ale_gate     (ale_gate),
        .ale          (ale),
        .psen_n       (psen_n),
        .ext_fetch    (ext_fetch),
        .rst_held     (rst_held)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Entered at a falling edge where the design sits in phase 11.
    task automatic do_cycle(input bit xd, input bit ct, input bit gt,
                            input bit ea, input logic [15:0] addr, input bit scr);
        logic [11:0] exp_ale, exp_psn, got_ale, got_psn;
        bit          exp_ext, got_ext, en, held_seen;
        string       ra, rp, re;
        xdata_cyc = xd; code_tbl_cyc = ct; ale_gate = gt;
        ea_pin = ea; fetch_addr = addr;
        exp_ext = !ea || (addr > 16'h0FFF);
        en      = !gt || xd || ct;
        for (int p = 0; p < 12; p++) begin
            exp_ale[p] = en && ((p < 2) || (p >= 6 && p < 8 && !xd));
            exp_psn[p] = !(exp_ext && !xd && ((p >= 2 && p < 6) || p >= 8));
        end
        held_seen = 1'b0;
        got_ext   = 1'b0;
        for (int p = 0; p < 12; p++) begin
            @(negedge clk);
            got_ale[p] = ale;
            got_psn[p] = psen_n;
            held_seen  = held_seen | rst_held;
            if (p == 0) got_ext = ext_fetch;
            if (scr && p == 4) begin
                xdata_cyc = ~xd; code_tbl_cyc = ~ct; ale_gate = ~gt;
                ea_pin = ~ea; fetch_addr = addr ^ 16'hF000;
            end
        end
        ra = scr ? "R9" : (xd ? "R2" : (gt ? "R3" : "R1"));
        rp = scr ? "R9" : (xd ? "R5" : (!exp_ext ? "R6" : "R4"));
        re = scr ? "R9" : (ea ? "R8" : "R7");
        check(got_ale == exp_ale, ra, "ale phase pattern", 32'(got_ale), 32'(exp_ale));
        check(got_psn == exp_psn, rp, "psen_n phase pattern", 32'(got_psn), 32'(exp_psn));
        check(got_ext == exp_ext, re, "ext_fetch", 32'(got_ext), 32'(exp_ext));
        check(!held_seen, "R11", "rst_held low during running cycle", 32'(held_seen), 32'd0);
    endtask

    // Entered at a falling edge in phase 11.
    task automatic rst_probe(input int n_high);
        rst_pin = 1'b1;
        for (int k = 1; k <= n_high; k++) begin
            @(negedge clk);
            if (k == 23) check(rst_held == 1'b0, "R10", "held after 23 edges", 32'(rst_held), 32'd0);
            if (k == 24) check(rst_held == 1'b1, "R10", "held after 24 edges", 32'(rst_held), 32'd1);
            if (k > 24)  check(!ale && psen_n, "R11", "strobes idle in reset",
                               {30'd0, ale, psen_n}, 32'd1);
        end
        rst_pin = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; rst_pin = 1'b0; ea_pin = 1'b1; fetch_addr = 16'h0;
        xdata_cyc = 1'b0; code_tbl_cyc = 1'b0; ale_gate = 1'b0;
        repeat (3) @(negedge clk);
        // R12 reset state
        check(ale == 1'b0,       "R12", "ale in reset",       32'(ale), 32'd0);
        check(psen_n == 1'b1,    "R12", "psen_n in reset",    32'(psen_n), 32'd1);
        check(rst_held == 1'b0,  "R12", "rst_held in reset",  32'(rst_held), 32'd0);
        check(ext_fetch == 1'b0, "R12", "ext_fetch in reset", 32'(ext_fetch), 32'd0);
        rst_n = 1'b1;

        // Full sweep of flags, pin level and boundary addresses (R1-R8, R12 restart)
        for (int x = 0; x < 2; x++)
            for (int c = 0; c < 2; c++)
                for (int g = 0; g < 2; g++)
                    for (int e = 0; e < 2; e++)
                        for (int a = 0; a < 4; a++) begin
                            logic [15:0] ad;
                            ad = (a == 0) ? 16'h0000 : (a == 1) ? 16'h0FFF :
                                 (a == 2) ? 16'h1000 : 16'hFFFF;
                            do_cycle(x[0], c[0], g[0], e[0], ad, 1'b0);
                        end

        // R9: mid-cycle input changes ignored
        do_cycle(1'b0, 1'b0, 1'b0, 1'b1, 16'h1000, 1'b1);
        do_cycle(1'b1, 1'b0, 1'b1, 1'b0, 16'h0000, 1'b1);
        do_cycle(1'b0, 1'b1, 1'b1, 1'b1, 16'h0FFF, 1'b1);

        // R10: 23 edges high are not enough; then one low edge keeps phase alignment
        rst_probe(23);
        @(negedge clk);
        check(rst_held == 1'b0, "R10", "held after short pulse", 32'(rst_held), 32'd0);
        do_cycle(1'b0, 1'b0, 1'b0, 1'b0, 16'h2000, 1'b0);

        // R10/R11: full hold, then release restarts at phase 0
        rst_probe(30);
        do_cycle(1'b0, 1'b0, 1'b0, 1'b0, 16'h0100, 1'b0);
        check(rst_held == 1'b0, "R10", "held falls after release", 32'(rst_held), 32'd0);
        do_cycle(1'b1, 1'b0, 1'b0, 1'b0, 16'h0100, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule